// File: doc/BRIEF.md
# Time-Coded Integrate-and-Fire Layer

This block runs one small layer of integrate-and-fire neurons over a fixed window of discrete ticks. At the start of a window it converts a frame of pixel intensities into first-spike times, so brighter pixels fire earlier. Once an input line has fired it stays active until the window ends. On every tick, each neuron adds the weights of all active inputs to its accumulator. There is no leak and no refractory logic. A neuron fires once when its accumulator rises above a threshold that all neurons share. Its fire flag and fire time then stay as they are until the next window starts.

The block also captures the first neuron to fire and the tick it fired on, which a winner-takes-all learning stage can use. The weights come in as a flat register array, one unsigned fraction per synapse. A start pulse launches a window. A single-cycle done pulse marks the end of it, and all results are then held stable for the reader.

Top module: `tc_if_layer`

## Requirements
- R1: Each input's spike tick is floor(WINDOW·(RMAX − c)/RMAX), where c is the pixel intensity clamped to RMAX (default WINDOW=100, RMAX=250). Intensity 250 or above gives tick 0. Intensity 0 gives tick WINDOW, so that input never becomes active.
- R2: An input is active on every tick k, with 0 ≤ k < WINDOW, for which k ≥ its spike tick. It stays active to the end of the window.
- R3: On each tick, a neuron's accumulator grows by the sum of the weights of its active inputs and never decreases within a window. Input i of neuron j uses the weight in bits [(j·N_IN+i)·8 +: 8] of `syn_w`.
- R4: A neuron fires on the first tick k on which its updated accumulator is strictly greater than THRESH (default 2000). Equality does not fire. Its fire time, in bits [j·7 +: 7] of `spk_time`, is k.
- R5: A neuron fires at most once per window. Its bit in `spk_flag` and its fire time stay unchanged until the next accepted start.
- R6: `win_valid` rises on the tick of the earliest firing. `win_idx` gives the lowest-index neuron among those that fired on that tick, and `win_time` gives that tick. If no neuron fires, `win_valid` stays 0.
- R7: If `start` is sampled high at edge 0 while the block is idle, the window's ticks run on edges 1..WINDOW. `busy` is high during those ticks. `done` is high for exactly the one cycle that follows edge WINDOW.
- R8: A start pulse while `busy` is high is ignored. The pixel frame is captured only when a start is accepted, so pixel changes during a window have no effect.
- R9: After reset, `busy`, `done`, `win_valid` and all `spk_flag` bits are 0.
- R10: An accepted start clears every accumulator, fire flag and winner record before the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a window when the block is idle |
| pix | input | N_IN·8 | Pixel intensities, input i in bits [i·8 +: 8] |
| syn_w | input | N_NEUR·N_IN·8 | Synaptic weights, unsigned fractions of 1.0 |
| busy | output | 1 | A window is in progress |
| done | output | 1 | One-cycle pulse after the last tick |
| spk_flag | output | N_NEUR | Per-neuron fired flag |
| spk_time | output | N_NEUR·7 | Per-neuron fire tick |
| win_valid | output | 1 | A first firing neuron has been captured |
| win_idx | output | 2 | Index of the first firing neuron |
| win_time | output | 7 | Tick of the first firing |

## Verification
A wrong spike-time latch or a wrong active mask changes how fast a neuron accumulates. That shows up as a fire tick off by one or more in `spk_time`, visible in the done cycle of that same window. A miscounted tick counter moves the `done` pulse away from WINDOW+1 cycles after start. An accumulator that is not cleared makes the next window fire too early or report a stale flag, so the error is visible one window later. A wrong tie-break or capture in the winner record disagrees with the per-neuron times in the same done cycle.

// File: rtl/tc_if_pkg.sv
package tc_if_pkg;

   function automatic int unsigned spike_tick(input int unsigned inten,
                                              input int unsigned rmax,
                                              input int unsigned window);
      int unsigned c;
      c = (inten > rmax) ? rmax : inten;
      return (window * (rmax - c)) / rmax;
   endfunction

   function automatic int unsigned width_of(input longint unsigned v);
      int unsigned w;
      w = 1;
      while ((longint'(1) << w) <= v) w++;
      return w;
   endfunction

endpackage

// File: rtl/tc_if_encoder.sv
module tc_if_encoder
   import tc_if_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int IW     = 8,
   parameter int WINDOW = 100,
   parameter int RMAX   = 250,
   parameter int TW     = 7
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [N_IN*IW-1:0] pix,
   input  logic [TW-1:0]      tick,
   output logic [N_IN-1:0]    active
);
   localparam int STW = TW + 1;

   logic [STW-1:0] t_spk [N_IN];

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            t_spk[i] <= STW'(WINDOW);
         else if (load)
            t_spk[i] <= STW'(spike_tick(int'(pix[i*IW +: IW]), RMAX, WINDOW));
      end
      assign active[i] = ({1'b0, tick} >= t_spk[i]);
   end
endmodule

// File: rtl/tc_if_neuron.sv
module tc_if_neuron #(
   parameter int N_IN   = 8,
   parameter int WW     = 8,
   parameter int AW     = 18,
   parameter int TW     = 7,
   parameter longint unsigned THRESH = 2000
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               step,
   input  logic [TW-1:0]      tick,
   input  logic [N_IN-1:0]    active,
   input  logic [N_IN*WW-1:0] w_row,
   output logic               fired,
   output logic [TW-1:0]      f_time,
   output logic               fire_now
);
   logic [AW-1:0] acc;
   logic [AW-1:0] inc;
   logic [AW-1:0] acc_nx;

   always_comb begin
      inc = '0;
      for (int i = 0; i < N_IN; i++)
         if (active[i]) inc = inc + AW'(w_row[i*WW +: WW]);
   end

   assign acc_nx   = acc + inc;
   assign fire_now = step && !fired && (acc_nx > AW'(THRESH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         fired  <= 1'b0;
         f_time <= '0;
      end else if (clear) begin
         acc    <= '0;
         fired  <= 1'b0;
         f_time <= '0;
      end else if (step) begin
         acc <= acc_nx;
         if (fire_now) begin
            fired  <= 1'b1;
            f_time <= tick;
         end
      end
   end
endmodule

// File: rtl/tc_if_winner.sv
module tc_if_winner #(
   parameter int N_NEUR = 4,
   parameter int XW     = 2,
   parameter int TW     = 7
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [TW-1:0]     tick,
   input  logic [N_NEUR-1:0] fire_now,
   output logic              w_valid,
   output logic [XW-1:0]     w_idx,
   output logic [TW-1:0]     w_time
);
   logic [XW-1:0] low_idx;

   always_comb begin
      low_idx = '0;
      for (int j = N_NEUR - 1; j >= 0; j--)
         if (fire_now[j]) low_idx = XW'(j);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_valid <= 1'b0;
         w_idx   <= '0;
         w_time  <= '0;
      end else if (clear) begin
         w_valid <= 1'b0;
         w_idx   <= '0;
         w_time  <= '0;
      end else if (!w_valid && (|fire_now)) begin
         w_valid <= 1'b1;
         w_idx   <= low_idx;
         w_time  <= tick;
      end
   end
endmodule

// File: rtl/tc_if_layer.sv
module tc_if_layer
   import tc_if_pkg::*;
#(
   parameter int N_IN   = 8,
   parameter int N_NEUR = 4,
   parameter int IW     = 8,
   parameter int WW     = 8,
   parameter int WINDOW = 100,
   parameter int RMAX   = 250,
   parameter longint unsigned THRESH = 2000,
   localparam int TW    = width_of(longint'(WINDOW - 1)),
   localparam int XW    = (N_NEUR > 1) ? $clog2(N_NEUR) : 1,
   localparam int AW    = width_of(longint'(WINDOW) * N_IN * ((longint'(1) << WW) - 1))
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [N_IN*IW-1:0]       pix,
   input  logic [N_NEUR*N_IN*WW-1:0] syn_w,
   output logic                     busy,
   output logic                     done,
   output logic [N_NEUR-1:0]        spk_flag,
   output logic [N_NEUR*TW-1:0]     spk_time,
   output logic                     win_valid,
   output logic [XW-1:0]            win_idx,
   output logic [TW-1:0]            win_time
);
   if (WINDOW < 2) begin : g_bad_win
      $error("WINDOW must be at least 2");
   end
   if (RMAX < 1 || RMAX >= (1 << IW)) begin : g_bad_rmax
      $error("RMAX must be in 1 .. 2**IW-1");
   end
   if (N_IN < 1 || N_NEUR < 1) begin : g_bad_cnt
      $error("N_IN and N_NEUR must be positive");
   end
   if (THRESH >= (longint'(1) << AW)) begin : g_bad_th
      $error("THRESH is never reachable");
   end

   logic            accept;
   logic            last;
   logic [TW-1:0]   tick;
   logic [N_IN-1:0] active;
   logic [N_NEUR-1:0] fire_now;

   assign accept = start && !busy;
   assign last   = busy && (tick == TW'(WINDOW - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         tick <= '0;
      end else begin
         done <= last;
         if (accept) begin
            busy <= 1'b1;
            tick <= '0;
         end else if (busy) begin
            if (last) busy <= 1'b0;
            else      tick <= tick + 1'b1;
         end
      end
   end

   tc_if_encoder #(
      .N_IN(N_IN), .IW(IW), .WINDOW(WINDOW), .RMAX(RMAX), .TW(TW)
   ) enc_i (
      .clk(clk), .rst_n(rst_n), .load(accept), .pix(pix),
      .tick(tick), .active(active)
   );

   for (genvar j = 0; j < N_NEUR; j++) begin : g_nrn
      tc_if_neuron #(
         .N_IN(N_IN), .WW(WW), .AW(AW), .TW(TW), .THRESH(THRESH)
      ) nrn_i (
         .clk(clk), .rst_n(rst_n), .clear(accept), .step(busy),
         .tick(tick), .active(active),
         .w_row(syn_w[j*N_IN*WW +: N_IN*WW]),
         .fired(spk_flag[j]), .f_time(spk_time[j*TW +: TW]),
         .fire_now(fire_now[j])
      );
   end

   tc_if_winner #(
      .N_NEUR(N_NEUR), .XW(XW), .TW(TW)
   ) win_i (
      .clk(clk), .rst_n(rst_n), .clear(accept), .tick(tick),
      .fire_now(fire_now), .w_valid(win_valid), .w_idx(win_idx),
      .w_time(win_time)
   );
endmodule

// File: rtl/tc_if_layer_chk.sv
module tc_if_layer_chk #(
   parameter int N_NEUR = 4,
   parameter int TW     = 7,
   parameter int XW     = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [N_NEUR-1:0] spk_flag,
   input logic [N_NEUR*TW-1:0] spk_time,
   input logic              win_valid,
   input logic [XW-1:0]     win_idx,
   input logic [TW-1:0]     win_time
);
   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   // R6
   win_fired_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> spk_flag[win_idx]);

   // R6
   win_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (spk_time[win_idx*TW +: TW] == win_time));

   // R6
   win_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spk_flag == '0) |-> !win_valid);

   for (genvar j = 0; j < N_NEUR; j++) begin : g_n
      // R5
      flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (spk_flag[j] && !(start && !busy)) |=> spk_flag[j]);

      // R5
      time_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (spk_flag[j] && !(start && !busy)) |=> $stable(spk_time[j*TW +: TW]));

      // R6
      win_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (win_valid && spk_flag[j]) |-> (spk_time[j*TW +: TW] >= win_time));

      // R6
      win_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (win_valid && spk_flag[j] && spk_time[j*TW +: TW] == win_time)
            |-> (XW'(j) >= win_idx));
   end
endmodule

bind tc_if_layer tc_if_layer_chk #(
   .N_NEUR(N_NEUR), .TW(TW), .XW(XW)
) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .spk_flag(spk_flag), .spk_time(spk_time), .win_valid(win_valid),
   .win_idx(win_idx), .win_time(win_time)
);

// File: tb/tc_if_layer_tb_top.sv
module tc_if_layer_tb_top;
   localparam int N_IN   = 8;
   localparam int N_NEUR = 4;
   localparam int WINDOW = 100;
   localparam int RMAX   = 250;
   localparam int TH     = 2000;
   localparam int TW     = 7;
   localparam int XW     = 2;
   localparam int NV     = 5;

   typedef struct packed {
      logic [N_IN*8-1:0] pix;
      logic [7:0]        seed;
   } vec_t;

   // pixel frame (input 7 in the top byte) and weight seed
   localparam vec_t VEC [NV] = '{
      '{pix: 64'h78FF_0032_6496_C8FA, seed: 8'd1},
      '{pix: 64'hFFFF_FFFF_FFFF_FFFF, seed: 8'd5},
      '{pix: 64'h0000_0000_F000_0000, seed: 8'd9},
      '{pix: 64'h8080_8080_8080_8080, seed: 8'd3},
      '{pix: 64'h10E0_20D0_30C0_40B0, seed: 8'd7}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [N_IN*8-1:0]        pix = '0;
   logic [N_NEUR*N_IN*8-1:0] syn_w = '0;
   logic busy, done, win_valid;
   logic [N_NEUR-1:0]    spk_flag;
   logic [N_NEUR*TW-1:0] spk_time;
   logic [XW-1:0]        win_idx;
   logic [TW-1:0]        win_time;

   int n_chk = 0;
   int n_bad = 0;
   int e_fire [N_NEUR];
   int last_cnt;

   always #10 clk = ~clk;

   tc_if_layer dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .pix(pix), .syn_w(syn_w),
      .busy(busy), .done(done), .spk_flag(spk_flag), .spk_time(spk_time),
      .win_valid(win_valid), .win_idx(win_idx), .win_time(win_time)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int st_of(input int p);
      int c;
      c = (p > RMAX) ? RMAX : p;
      return (WINDOW * (RMAX - c)) / RMAX;
   endfunction

   // expected fire tick per neuron, -1 if none
   task automatic model();
      int acc;
      for (int j = 0; j < N_NEUR; j++) begin
         acc = 0;
         e_fire[j] = -1;
         for (int k = 0; k < WINDOW; k++) begin
            for (int i = 0; i < N_IN; i++)
               if (k >= st_of(int'(pix[i*8 +: 8])))
                  acc += int'(syn_w[(j*N_IN+i)*8 +: 8]);
            if (e_fire[j] < 0 && acc > TH) e_fire[j] = k;
         end
      end
   endtask

   task automatic run_window(input bit poke_mid);
      int cnt = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      while (!done && cnt < 1000) begin
         if (poke_mid && cnt == 20) begin
            start = 1'b1;
            pix = '0;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cnt++;
      end
      start = 1'b0;
      last_cnt = cnt;
   endtask

   task automatic check_all(input string tag);
      int bt = -1;
      int bi = 0;
      for (int j = 0; j < N_NEUR; j++) begin
         chk(spk_flag[j] == (e_fire[j] >= 0), {tag, " R4 flag"},
             int'(spk_flag[j]), int'(e_fire[j] >= 0));
         if (e_fire[j] >= 0) begin
            chk(int'(spk_time[j*TW +: TW]) == e_fire[j], {tag, " R3 R4 time"},
                int'(spk_time[j*TW +: TW]), e_fire[j]);
            if (bt < 0 || e_fire[j] < bt) begin
               bt = e_fire[j];
               bi = j;
            end
         end
      end
      chk(win_valid == (bt >= 0), {tag, " R6 valid"}, int'(win_valid), int'(bt >= 0));
      if (bt >= 0) begin
         chk(int'(win_idx) == bi, {tag, " R6 idx"}, int'(win_idx), bi);
         chk(int'(win_time) == bt, {tag, " R6 time"}, int'(win_time), bt);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(!busy && !done && !win_valid && spk_flag == '0, "R9 reset",
          int'({busy, done, win_valid, spk_flag}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int v = 0; v < NV; v++) begin
         pix = VEC[v].pix;
         for (int j = 0; j < N_NEUR; j++)
            for (int i = 0; i < N_IN; i++)
               syn_w[(j*N_IN+i)*8 +: 8] =
                  8'((int'(VEC[v].seed) * 13 + j * 57 + i * 29 + int'(VEC[v].seed) * j * 7) & 255);
         model();
         run_window(1'b0);
         chk(last_cnt == WINDOW + 1, "R7 latency", last_cnt, WINDOW + 1);
         check_all($sformatf("vec%0d R1 R2", v));
      end

      // strict threshold: single input at tick 0, weight 200 -> fire on tick 10
      pix = '0;
      pix[7:0] = 8'd250;
      syn_w = '0;
      syn_w[7:0] = 8'd200;
      run_window(1'b0);
      chk(spk_flag[0] && int'(spk_time[TW-1:0]) == 10, "R4 strict",
          int'(spk_time[TW-1:0]), 10);

      // R1 clamp: 255 behaves as 250; 249 gives tick floor(100/250)=0 too, 125 gives 50
      pix = '0;
      pix[7:0] = 8'd125;
      run_window(1'b0);
      // acc after tick k = 200*(k-49); >2000 at k=60
      chk(int'(spk_time[TW-1:0]) == 60, "R1 R2 mid intensity",
          int'(spk_time[TW-1:0]), 60);

      // tie: neuron 0 silent, neurons 1..3 identical -> R6 picks 1 at tick 2
      pix = '1;
      for (int j = 0; j < N_NEUR; j++)
         for (int i = 0; i < N_IN; i++)
            syn_w[(j*N_IN+i)*8 +: 8] = (j == 0) ? 8'd0 : 8'd100;
      run_window(1'b0);
      chk(win_valid && win_idx == 1, "R6 tie idx", int'(win_idx), 1);
      chk(int'(win_time) == 2, "R6 tie time", int'(win_time), 2);
      chk(spk_flag == 4'b1110, "R5 tie flags", int'(spk_flag), 14);

      // R8: start and pixel drop mid-window ignored
      pix = '1;
      run_window(1'b1);
      chk(last_cnt == WINDOW + 1, "R8 latency", last_cnt, WINDOW + 1);
      chk(win_valid && int'(win_time) == 2 && win_idx == 1, "R8 result",
          int'(win_time), 2);

      // R10: dark frame clears everything from the previous window
      pix = '0;
      run_window(1'b0);
      chk(spk_flag == '0, "R10 flags cleared", int'(spk_flag), 0);
      chk(!win_valid, "R10 R6 no winner", int'(win_valid), 0);

      // R5: results held after done
      repeat (5) @(negedge clk);
      chk(spk_flag == '0 && !busy && !done, "R5 hold idle",
          int'({busy, done, spk_flag}), 0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule